// File: doc/BRIEF.md
# Dual-Cluster Power Controller Register Slave

This block is the register face of a power controller that serves two processor clusters: a "big" cluster and a "little" cluster. Software writes 32-bit words to set a performance level for either cluster, or to issue a configuration command. Each of these writes starts an operation that takes a long time. Only one operation can be in flight at a time. When the operation ends, the block records a completion flag or an error flag in a field of the status register that belongs to the request type. It then holds a level-high interrupt until software reads the status register.

The same slave also holds several other registers:
- the wake-up enable mask;
- one resume-address mailbox per CPU;
- a power-down enable for each cluster;
- a read-only word that reports which CPUs are idle in wait-for-interrupt.

The real voltage and frequency sequencer and the configuration bus are stood in for by a responder with a fixed, parameterised latency. A successful configuration read returns a value that is computed from the requested word offset.

Top module: `pwrc_regif`

## Requirements
- R1: After reset, every register reads zero and `irq` is low.
- R2: A write to offset 0x00 (big cluster, request type 0) or offset 0x08 (little cluster, request type 1) starts an operation when the block is idle.
  - A value below NUM_LEVELS (8) sets status bit 4t exactly LATENCY cycles after the write edge. From then on the level register at that offset reads the new value.
  - A value of NUM_LEVELS or above sets bit 4t+1 instead and leaves the level unchanged.
- R3: A write to the command word at 0x10 with bit 31 set starts a configuration access (request type 2).
  - When bits 23:20 equal 6, bit 8 is set after LATENCY cycles, and 0x74 then reads 0xCF000000 OR the offset in bits 11:0.
  - Any other function code sets bit 9 and leaves 0x74 unchanged.
  - A command write with bit 31 clear only stores the word, which reads back at 0x10, and starts nothing.
- R4: A read of the status register at 0x18 returns the flags and clears them all at that clock edge. A flag posted at the same edge survives the clear.
- R5: `irq` is high exactly while at least one status flag is set.
- R6: A start request (R2 or R3) made while an operation is busy sets that type's error bit at the next edge. It changes no level, command or data register, and the running operation completes normally.
- R7: The wake mask at 0x24 keeps only these bits: n for big CPU n, 4+n for little CPU n, and the global enables 11:10. All other bits read zero.
- R8: The power-down enables at 0x30 (big) and 0x34 (little) keep only bit 0.
- R9: The 32-bit resume mailboxes are at 0x68+4n for big CPU n and 0x78+4n for little CPU n. Each reads back what was last written to it.
- R10: The standby word at 0x3C reads big CPU n's idle input at bit n and little CPU n's idle input at bit 3+n. Writes to 0x3C have no effect.
- R11: A read of any unmapped offset returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe, one cycle per write |
| rdEn | input | 1 | Register read strobe; a status read clears the flags |
| addr | input | 8 | Byte offset of the access |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, combinational from `addr` |
| standbyBig | input | BIG_CPUS | Wait-for-interrupt indication per big-cluster CPU |
| standbyLittle | input | LITTLE_CPUS | Wait-for-interrupt indication per little-cluster CPU |
| irq | output | 1 | Level-high operation-ended interrupt |

## Verification
The hardest case to reach from the ports is a status read that falls on the exact edge where an operation posts its result. Only a precise alignment shows whether the new flag survives the clear. The stimulus therefore issues a status read on every cycle across the whole latency window of an operation, so that one read is certain to land on the completion edge. Busy rejection is reached by issuing a second start on the cycle right after the first. The behavioural model predicts both cases, and its status and interrupt are compared with the design on every clock.

// File: rtl/pwrc_pkg.sv
package pwrc_pkg;

  localparam int ADDR_W = 8;
  localparam int STS_W  = 12;
  localparam int OFF_W  = 12;
  localparam int CMD_GO_BIT = 31;
  localparam int LITTLE_STBY_POS = 3;
  localparam logic [31:0] CFG_SIG = 32'hCF00_0000;

  localparam logic [ADDR_W-1:0] ADDR_LVL_BIG    = 8'h00;
  localparam logic [ADDR_W-1:0] ADDR_LVL_LITTLE = 8'h08;
  localparam logic [ADDR_W-1:0] ADDR_CMD        = 8'h10;
  localparam logic [ADDR_W-1:0] ADDR_STS        = 8'h18;
  localparam logic [ADDR_W-1:0] ADDR_WAKE       = 8'h24;
  localparam logic [ADDR_W-1:0] ADDR_PD_BIG     = 8'h30;
  localparam logic [ADDR_W-1:0] ADDR_PD_LITTLE  = 8'h34;
  localparam logic [ADDR_W-1:0] ADDR_STBY       = 8'h3C;
  localparam logic [ADDR_W-1:0] ADDR_MB_BIG     = 8'h68;
  localparam logic [ADDR_W-1:0] ADDR_CFG_DATA   = 8'h74;
  localparam logic [ADDR_W-1:0] ADDR_MB_LITTLE  = 8'h78;

  typedef enum logic [1:0] {
    REQ_BIG    = 2'd0,
    REQ_LITTLE = 2'd1,
    REQ_CFG    = 2'd2
  } reqType_e;

  // strobes from control to datapath
  typedef struct packed {
    logic     start;
    reqType_e startKind;
    logic     commit;
    reqType_e commitKind;
  } opStrobe_t;

  function automatic logic [STS_W-1:0] flagBit(reqType_e kind, logic isErr);
    logic [3:0] pos;
    pos = {kind, 2'b00} | {3'b000, isErr};
    return STS_W'(1) << pos;
  endfunction

endpackage

// File: rtl/pwrc_ctrl.sv
module pwrc_ctrl
  import pwrc_pkg::*;
#(
  parameter int NUM_LEVELS = 8,
  parameter int LATENCY    = 16,
  parameter int CFG_FUNC   = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  output opStrobe_t         strb,
  output logic [STS_W-1:0]  status,
  output logic              busy,
  output logic              done,
  output logic              reject,
  output logic [$clog2(LATENCY+1)-1:0] cnt
);

  localparam int CNT_W = $clog2(LATENCY+1);

  logic     startReq;
  logic     reqBad;
  reqType_e reqKind;
  reqType_e curKind;
  logic     curBad;
  logic     accept;
  logic     stsRead;
  logic [STS_W-1:0] newFlags;

  always_comb begin
    startReq = 1'b0;
    reqKind  = REQ_CFG;
    reqBad   = 1'b0;
    if (wrEn) begin
      case (addr)
        ADDR_LVL_BIG: begin
          startReq = 1'b1;
          reqKind  = REQ_BIG;
          reqBad   = wrData >= 32'(NUM_LEVELS);
        end
        ADDR_LVL_LITTLE: begin
          startReq = 1'b1;
          reqKind  = REQ_LITTLE;
          reqBad   = wrData >= 32'(NUM_LEVELS);
        end
        ADDR_CMD: begin
          startReq = wrData[CMD_GO_BIT];
          reqKind  = REQ_CFG;
          reqBad   = wrData[23:20] != 4'(CFG_FUNC);
        end
        default: ;
      endcase
    end
  end

  assign done    = busy && (cnt == CNT_W'(1));
  assign accept  = startReq && !busy;
  assign reject  = startReq && busy;
  assign stsRead = rdEn && (addr == ADDR_STS);

  always_comb begin
    newFlags = '0;
    if (done)   newFlags = newFlags | flagBit(curKind, curBad);
    if (reject) newFlags = newFlags | flagBit(reqKind, 1'b1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      cnt     <= '0;
      curKind <= REQ_BIG;
      curBad  <= 1'b0;
      status  <= '0;
    end else begin
      status <= (stsRead ? '0 : status) | newFlags;
      if (accept) begin
        busy    <= 1'b1;
        cnt     <= CNT_W'(LATENCY);
        curKind <= reqKind;
        curBad  <= reqBad;
      end else if (busy) begin
        cnt <= cnt - CNT_W'(1);
        if (done) busy <= 1'b0;
      end
    end
  end

  assign strb.start      = accept;
  assign strb.startKind  = reqKind;
  assign strb.commit     = done && !curBad;
  assign strb.commitKind = curKind;

endmodule

// File: rtl/pwrc_datapath.sv
module pwrc_datapath
  import pwrc_pkg::*;
#(
  parameter int NUM_LEVELS  = 8,
  parameter int BIG_CPUS    = 2,
  parameter int LITTLE_CPUS = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  input  opStrobe_t         strb,
  input  logic [STS_W-1:0]  status,
  input  logic [BIG_CPUS-1:0]    standbyBig,
  input  logic [LITTLE_CPUS-1:0] standbyLittle,
  output logic [31:0]       rdData,
  output logic [$clog2(NUM_LEVELS)-1:0] lvlBigOut
);

  localparam int LVL_W = $clog2(NUM_LEVELS);
  localparam logic [31:0] WAKE_KEEP = 32'((1 << BIG_CPUS) - 1)
                                    | (32'((1 << LITTLE_CPUS) - 1) << 4)
                                    | 32'h0000_0C00;

  logic [LVL_W-1:0] lvlBig, lvlLittle, pendLvl;
  logic [OFF_W-1:0] pendOff;
  logic [31:0] cmdReg, cfgData, wakeMask;
  logic pdBig, pdLittle;
  logic [31:0] mbBig [BIG_CPUS];
  logic [31:0] mbLittle [LITTLE_CPUS];
  logic [31:0] stbyWord;
  logic cmdPlain;

  assign cmdPlain = wrEn && (addr == ADDR_CMD) && !wrData[CMD_GO_BIT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lvlBig    <= '0;
      lvlLittle <= '0;
      pendLvl   <= '0;
      pendOff   <= '0;
      cmdReg    <= '0;
      cfgData   <= '0;
    end else begin
      if (strb.start) begin
        if (strb.startKind == REQ_CFG) begin
          cmdReg  <= wrData;
          pendOff <= wrData[OFF_W-1:0];
        end else begin
          pendLvl <= wrData[LVL_W-1:0];
        end
      end else if (cmdPlain) begin
        cmdReg <= wrData;
      end
      if (strb.commit) begin
        case (strb.commitKind)
          REQ_BIG:    lvlBig    <= pendLvl;
          REQ_LITTLE: lvlLittle <= pendLvl;
          default:    cfgData   <= CFG_SIG | 32'(pendOff);
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wakeMask <= '0;
      pdBig    <= 1'b0;
      pdLittle <= 1'b0;
    end else if (wrEn) begin
      if (addr == ADDR_WAKE)      wakeMask <= wrData & WAKE_KEEP;
      if (addr == ADDR_PD_BIG)    pdBig    <= wrData[0];
      if (addr == ADDR_PD_LITTLE) pdLittle <= wrData[0];
    end
  end

  for (genvar i = 0; i < BIG_CPUS; i++) begin : g_mbBig
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) mbBig[i] <= '0;
      else if (wrEn && addr == ADDR_MB_BIG + ADDR_W'(4 * i)) mbBig[i] <= wrData;
    end
  end

  for (genvar i = 0; i < LITTLE_CPUS; i++) begin : g_mbLittle
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) mbLittle[i] <= '0;
      else if (wrEn && addr == ADDR_MB_LITTLE + ADDR_W'(4 * i)) mbLittle[i] <= wrData;
    end
  end

  always_comb begin
    stbyWord = '0;
    stbyWord[BIG_CPUS-1:0] = standbyBig;
    stbyWord[LITTLE_STBY_POS +: LITTLE_CPUS] = standbyLittle;
  end

  always_comb begin
    rdData = '0;
    case (addr)
      ADDR_LVL_BIG:    rdData = 32'(lvlBig);
      ADDR_LVL_LITTLE: rdData = 32'(lvlLittle);
      ADDR_CMD:        rdData = cmdReg;
      ADDR_STS:        rdData = 32'(status);
      ADDR_WAKE:       rdData = wakeMask;
      ADDR_PD_BIG:     rdData = {31'd0, pdBig};
      ADDR_PD_LITTLE:  rdData = {31'd0, pdLittle};
      ADDR_STBY:       rdData = stbyWord;
      ADDR_CFG_DATA:   rdData = cfgData;
      default: begin
        for (int i = 0; i < BIG_CPUS; i++)
          if (addr == ADDR_MB_BIG + ADDR_W'(4 * i)) rdData = mbBig[i];
        for (int i = 0; i < LITTLE_CPUS; i++)
          if (addr == ADDR_MB_LITTLE + ADDR_W'(4 * i)) rdData = mbLittle[i];
      end
    endcase
  end

  assign lvlBigOut = lvlBig;

endmodule

// File: rtl/pwrc_regif.sv
module pwrc_regif
  import pwrc_pkg::*;
#(
  parameter int NUM_LEVELS  = 8,
  parameter int LATENCY     = 16,
  parameter int CFG_FUNC    = 6,
  parameter int BIG_CPUS    = 2,
  parameter int LITTLE_CPUS = 3
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   wrEn,
  input  logic                   rdEn,
  input  logic [7:0]             addr,
  input  logic [31:0]            wrData,
  output logic [31:0]            rdData,
  input  logic [BIG_CPUS-1:0]    standbyBig,
  input  logic [LITTLE_CPUS-1:0] standbyLittle,
  output logic                   irq
);

  localparam int CNT_W = $clog2(LATENCY + 1);
  localparam int LVL_W = $clog2(NUM_LEVELS);

  opStrobe_t        strb;
  logic [STS_W-1:0] status;
  logic             busyW, doneW, rejectW;
  logic [CNT_W-1:0] cntW;
  logic [LVL_W-1:0] lvlBigW;
  logic             commitBigW;

  pwrc_ctrl #(
    .NUM_LEVELS(NUM_LEVELS), .LATENCY(LATENCY), .CFG_FUNC(CFG_FUNC)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .strb(strb), .status(status), .busy(busyW),
    .done(doneW), .reject(rejectW), .cnt(cntW)
  );

  pwrc_datapath #(
    .NUM_LEVELS(NUM_LEVELS), .BIG_CPUS(BIG_CPUS), .LITTLE_CPUS(LITTLE_CPUS)
  ) dp_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .strb(strb), .status(status), .standbyBig(standbyBig),
    .standbyLittle(standbyLittle), .rdData(rdData), .lvlBigOut(lvlBigW)
  );

  assign irq        = |status;
  assign commitBigW = strb.commit && (strb.commitKind == REQ_BIG);

endmodule

// File: rtl/pwrc_regif_chk.sv
module pwrc_regif_chk #(
  parameter int LATENCY = 16,
  parameter int CNT_W   = 5,
  parameter int LVL_W   = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             rdEn,
  input logic             wrEn,
  input logic [7:0]       addr,
  input logic             irq,
  input logic             busy,
  input logic             done,
  input logic             reject,
  input logic [CNT_W-1:0] cnt,
  input logic             commitBig,
  input logic [LVL_W-1:0] lvlBig
);

  // R4: a status read with nothing posted leaves irq low
  assert_irq_clear_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == 8'h18 && !done && !reject) |=> !irq);

  // R5: irq stays up until a status read
  assert_irq_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !(rdEn && addr == 8'h18)) |=> irq);

  // R6: a start on a busy block raises the interrupt at the next edge
  assert_busy_reject_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busy && wrEn && (addr == 8'h00 || addr == 8'h08)) |=> irq);

  // R2: the big level moves only on a successful commit
  assert_level_stable_R2: assert property (@(posedge clk) disable iff (!rstN)
    !commitBig |=> $stable(lvlBig));

  // R2: latency counter stays within its window and rests at zero when idle
  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= CNT_W'(LATENCY));

  assert_idle_count_R2: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> cnt == '0);

endmodule

bind pwrc_regif pwrc_regif_chk #(
  .LATENCY(LATENCY), .CNT_W(CNT_W), .LVL_W(LVL_W)
) chk_i (
  .clk(clk), .rstN(rstN), .rdEn(rdEn), .wrEn(wrEn), .addr(addr), .irq(irq),
  .busy(busyW), .done(doneW), .reject(rejectW), .cnt(cntW),
  .commitBig(commitBigW), .lvlBig(lvlBigW)
);

// File: tb/pwrc_regif_tb.sv
`timescale 1ns/1ps
module pwrc_regif_tb_top;

  localparam int LAT = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0, rdEn = 1'b0;
  logic [7:0] addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [1:0] standbyBig = 2'b10;
  logic [2:0] standbyLittle = 3'b101;
  logic irq;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  pwrc_regif #(.LATENCY(LAT)) dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .standbyBig(standbyBig),
    .standbyLittle(standbyLittle), .irq(irq)
  );

  // behavioural reference model
  logic [11:0] mSts;
  bit   mBusy, mBad;
  int   mCnt, mKind;
  int   mLvlB, mLvlL, mPend, mPendOff;
  logic [31:0] mCmd, mCfg, mWake;
  bit   mPdB, mPdL;
  logic [31:0] mMbB [2];
  logic [31:0] mMbL [3];

  always @(posedge clk or negedge rstN) begin : model
    logic [11:0] nf;
    bit wasBusy, isStart;
    int k;
    if (!rstN) begin
      mSts = '0; mBusy = 0; mBad = 0; mCnt = 0; mKind = 0;
      mLvlB = 0; mLvlL = 0; mPend = 0; mPendOff = 0;
      mCmd = '0; mCfg = '0; mWake = '0; mPdB = 0; mPdL = 0;
      for (int i = 0; i < 2; i++) mMbB[i] = '0;
      for (int i = 0; i < 3; i++) mMbL[i] = '0;
    end else begin
      nf = '0;
      wasBusy = mBusy;
      isStart = wrEn && (addr == 8'h00 || addr == 8'h08 || (addr == 8'h10 && wrData[31]));
      k = (addr == 8'h00) ? 0 : (addr == 8'h08) ? 1 : 2;
      if (mBusy) begin
        if (mCnt == 1) begin
          nf = nf | (12'd1 << (4 * mKind + (mBad ? 1 : 0)));
          if (!mBad) begin
            if (mKind == 0) mLvlB = mPend;
            else if (mKind == 1) mLvlL = mPend;
            else mCfg = 32'hCF00_0000 | 32'(mPendOff);
          end
          mBusy = 0;
          mCnt = 0;
        end else mCnt = mCnt - 1;
      end
      if (isStart) begin
        if (wasBusy) nf = nf | (12'd1 << (4 * k + 1));
        else begin
          mBusy = 1; mCnt = LAT; mKind = k;
          if (k < 2) begin
            mBad = wrData >= 32'd8;
            mPend = int'(wrData[2:0]);
          end else begin
            mBad = wrData[23:20] != 4'd6;
            mCmd = wrData;
            mPendOff = int'(wrData[11:0]);
          end
        end
      end else if (wrEn) begin
        case (addr)
          8'h10: mCmd = wrData;
          8'h24: mWake = wrData & 32'h0000_0C73;
          8'h30: mPdB = wrData[0];
          8'h34: mPdL = wrData[0];
          8'h68: mMbB[0] = wrData;
          8'h6C: mMbB[1] = wrData;
          8'h78: mMbL[0] = wrData;
          8'h7C: mMbL[1] = wrData;
          8'h80: mMbL[2] = wrData;
          default: ;
        endcase
      end
      if (rdEn && addr == 8'h18) mSts = '0;
      mSts = mSts | nf;
    end
  end

  function automatic logic [31:0] expRead(logic [7:0] a);
    case (a)
      8'h00: return 32'(mLvlB);
      8'h08: return 32'(mLvlL);
      8'h10: return mCmd;
      8'h18: return 32'(mSts);
      8'h24: return mWake;
      8'h30: return {31'd0, mPdB};
      8'h34: return {31'd0, mPdL};
      8'h3C: return {26'd0, standbyLittle, 1'b0, standbyBig};
      8'h68: return mMbB[0];
      8'h6C: return mMbB[1];
      8'h74: return mCfg;
      8'h78: return mMbL[0];
      8'h7C: return mMbL[1];
      8'h80: return mMbL[2];
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // interrupt compared against the model on every clock (R5)
  always @(negedge clk) begin
    if (rstN) check(irq == (mSts != 0), "R5 irq", 32'(irq), 32'(mSts != 0));
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, string req, bit hasExp, logic [31:0] exp);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    #1;
    check(rdData == expRead(a), req, rdData, expRead(a));
    if (hasExp) check(rdData == exp, req, rdData, exp);
    @(posedge clk); #1;
    rdEn = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    failures++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    // R1 reset values
    rd(8'h18, "R1 status", 1, 32'd0);
    rd(8'h00, "R1 big level", 1, 32'd0);
    rd(8'h74, "R1 cfg data", 1, 32'd0);
    check(irq == 1'b0, "R1 irq", 32'(irq), 32'd0);

    // R2 valid big level
    wr(8'h00, 32'd5);
    idle(LAT + 2);
    rd(8'h00, "R2 big level", 1, 32'd5);
    rd(8'h18, "R2 big done flag", 1, 32'h001);
    // R4 cleared by the read
    rd(8'h18, "R4 cleared", 1, 32'h000);

    // R2 invalid little level
    wr(8'h08, 32'd9);
    idle(LAT + 2);
    rd(8'h18, "R2 little error flag", 1, 32'h020);
    rd(8'h08, "R2 little unchanged", 1, 32'd0);

    // R3 configuration read
    wr(8'h10, 32'h8060_0123);
    idle(LAT + 2);
    rd(8'h18, "R3 cfg done flag", 1, 32'h100);
    rd(8'h74, "R3 cfg data", 1, 32'hCF00_0123);
    // R3 bad function code
    wr(8'h10, 32'h8030_0044);
    idle(LAT + 2);
    rd(8'h18, "R3 cfg error flag", 1, 32'h200);
    rd(8'h74, "R3 cfg data kept", 1, 32'hCF00_0123);
    // R3 no start bit
    wr(8'h10, 32'h0060_0055);
    idle(LAT + 2);
    rd(8'h18, "R3 no op", 1, 32'h000);
    rd(8'h10, "R3 command stored", 1, 32'h0060_0055);

    // R6 reject while busy
    wr(8'h00, 32'd2);
    wr(8'h08, 32'd1);
    rd(8'h18, "R6 reject flag", 1, 32'h020);
    wr(8'h10, 32'h8060_0077);
    idle(LAT);
    rd(8'h18, "R6 original completes", 1, 32'h201);
    rd(8'h00, "R6 big level", 1, 32'd2);
    rd(8'h08, "R6 little untouched", 1, 32'd0);
    rd(8'h10, "R6 command untouched", 1, 32'h0060_0055);

    // R4 status reads on every cycle across a completion edge
    wr(8'h08, 32'd3);
    for (int i = 0; i < LAT + 3; i++) rd(8'h18, "R4 sweep", 0, 32'd0);
    rd(8'h08, "R2 little level", 1, 32'd3);

    // R7 wake mask
    wr(8'h24, 32'hFFFF_FFFF);
    rd(8'h24, "R7 wake mask", 1, 32'h0000_0C73);
    // R8 power-down enables
    wr(8'h30, 32'hFFFF_FFFF);
    wr(8'h34, 32'hFFFF_FFFE);
    rd(8'h30, "R8 big pd", 1, 32'd1);
    rd(8'h34, "R8 little pd", 1, 32'd0);
    // R9 mailboxes
    wr(8'h68, 32'h1000_0000);
    wr(8'h6C, 32'h1000_0004);
    wr(8'h78, 32'h2000_0000);
    wr(8'h7C, 32'h2000_0004);
    wr(8'h80, 32'h2000_0008);
    rd(8'h68, "R9 big0", 1, 32'h1000_0000);
    rd(8'h6C, "R9 big1", 1, 32'h1000_0004);
    rd(8'h78, "R9 little0", 1, 32'h2000_0000);
    rd(8'h7C, "R9 little1", 1, 32'h2000_0004);
    rd(8'h80, "R9 little2", 1, 32'h2000_0008);
    // R10 standby status
    rd(8'h3C, "R10 standby", 1, 32'h0000_002A);
    wr(8'h3C, 32'hFFFF_FFFF);
    standbyBig = 2'b01; standbyLittle = 3'b010;
    rd(8'h3C, "R10 standby after write", 1, 32'h0000_0011);
    // R11 unmapped
    rd(8'h40, "R11 unmapped", 1, 32'd0);
    rd(8'h84, "R11 past mailboxes", 1, 32'd0);

    idle(2);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule